// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one memory write transaction into a page-sized staging buffer, then hands them to a byte-wide memory array during a single internal programming cycle of fixed length. A transaction opens with a start request that carries a 14-bit byte address. The upper 8 bits choose one of 256 pages and stay latched for the whole transaction. The lower 6 bits give the first offset inside the 64-byte page. Each byte-load strobe stores one byte at the current offset and then advances only that offset, which wraps from 63 back to 0. Loading more bytes than remain before the page end therefore overwrites bytes loaded earlier.

A commit request, issued when the bus sees STOP, starts programming if at least one byte was loaded. Busy is then held for exactly `TWR_CYCLES` clock cycles. Inside that window the block sweeps the page offsets in ascending order, one per cycle, and pulses the array write strobe only for offsets that were loaded. Each such write carries the newest value loaded at that offset. An abort request, or a fresh start, throws away everything loaded so far. Requests that arrive while busy is high are ignored. The array itself, and all bus protocol handling, sit outside this block.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, `busy_o` is 0 and `arr_we_o` is 0.
- R2: A start request latches the page from address bits [13:6] and the first offset from bits [5:0]. Every array write of that transaction goes to address {latched page, offset}.
- R3: Each accepted byte load advances only the offset. The offset wraps from 63 to 0 and the page does not change.
- R4: A byte loaded again at an offset replaces the earlier value. Each loaded offset is written exactly once, with its newest value.
- R5: During programming, writes occur only while busy is high. They cover only offsets loaded in the current transaction, in ascending offset order.
- R6: A commit with at least one loaded byte raises `busy_o` in the next cycle. `busy_o` stays high for exactly `TWR_CYCLES` cycles.
- R7: A commit with no loaded bytes, or one that follows an abort, produces no write and leaves `busy_o` low.
- R8: A start request discards bytes loaded before it. Only bytes of the most recent transaction are programmed.
- R9: Start, load, commit and abort requests that arrive while `busy_o` is high have no effect. They neither lengthen busy nor change the bytes that are written.
- R10: When several requests arrive in one cycle, the priority is abort, then start, then commit, then load.
- R11: Once programming ends, the buffer is closed. Byte loads are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start_i | input | 1 | Opens a write transaction at `txn_addr_i` |
| txn_addr_i | input | 14 | Starting byte address: page in [13:6], offset in [5:0] |
| byte_load_i | input | 1 | Load strobe for `byte_data_i` |
| byte_data_i | input | 8 | Data byte to stage |
| commit_req_i | input | 1 | Commit request, issued on STOP |
| abort_req_i | input | 1 | Discards the staged bytes and closes the transaction |
| busy_o | output | 1 | High during the internal write cycle |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 14 | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
The bench loads a transaction that starts two bytes before the page end, to catch a design that carries the offset into the page number and so writes into the following page. It overfills a page with 70 bytes, which exposes a design that keeps the first value at an offset instead of the newest one, or that writes an offset twice. It sends commits with nothing staged, commits after an abort, and commits that arrive together with a start. A design that programs stale or discarded bytes in these cases shows up as an unexpected busy window or an unexpected write. Requests issued during busy check that the window is neither extended nor restarted and that foreign bytes do not leak into the array.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
   typedef enum logic [1:0] {
      PG_IDLE = 2'd0,
      PG_FILL = 2'd1,
      PG_PROG = 2'd2
   } pg_state_e;
endpackage

// File: rtl/pgb_cursor.sv
module pgb_cursor #(
   parameter int ADDR_W = 14,
   parameter int OFS_W  = 6,
   localparam int PAGE_W = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              step_i,
   output logic [PAGE_W-1:0] page_o,
   output logic [OFS_W-1:0]  ofs_o
);
   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         ofs_q  <= '0;
      end else if (latch_i) begin
         page_q <= addr_i[ADDR_W-1:OFS_W];
         ofs_q  <= addr_i[OFS_W-1:0];
      end else if (step_i) begin
         ofs_q  <= ofs_q + 1'b1;
      end
   end

   assign page_o = page_q;
   assign ofs_o  = ofs_q;
endmodule

// File: rtl/pgb_slots.sv
module pgb_slots #(
   parameter int SLOTS  = 64,
   parameter int DATA_W = 8,
   localparam int OFS_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wr_i,
   input  logic [OFS_W-1:0]  wr_ofs_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [OFS_W-1:0]  rd_ofs_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic              any_valid_o
);
   logic [SLOTS-1:0]  hit;
   logic [SLOTS-1:0]  valid_q;
   logic [DATA_W-1:0] data_q [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_dec
      assign hit[g] = wr_i && (wr_ofs_i == OFS_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         valid_q <= '0;
      end else begin
         valid_q <= valid_q | hit;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < SLOTS; i++) begin
         if (!rst_n) begin
            data_q[i] <= '0;
         end else if (hit[i]) begin
            data_q[i] <= wr_data_i;
         end
      end
   end

   assign rd_data_o   = data_q[rd_ofs_i];
   assign rd_valid_o  = valid_q[rd_ofs_i];
   assign any_valid_o = |valid_q;
endmodule

// File: rtl/pgb_ctrl.sv
module pgb_ctrl
   import pgb_pkg::*;
#(
   parameter int SLOTS      = 64,
   parameter int TWR_CYCLES = 80,
   localparam int OFS_W = $clog2(SLOTS),
   localparam int CNT_W = $clog2(TWR_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic             start_i,
   input  logic             commit_i,
   input  logic             load_i,
   input  logic             any_valid_i,
   output logic             busy_o,
   output logic             latch_o,
   output logic             step_o,
   output logic             clear_o,
   output logic             scan_on_o,
   output logic [OFS_W-1:0] scan_ofs_o
);
   pg_state_e  state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last_cyc;

   assign last_cyc = (cnt_q == CNT_W'(TWR_CYCLES - 1));

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      latch_o = 1'b0;
      step_o  = 1'b0;
      clear_o = 1'b0;
      if (state_q == PG_PROG) begin
         cnt_d = cnt_q + 1'b1;
         if (last_cyc) begin
            state_d = PG_IDLE;
            cnt_d   = '0;
            clear_o = 1'b1;
         end
      end else if (abort_i) begin
         state_d = PG_IDLE;
         clear_o = 1'b1;
      end else if (start_i) begin
         state_d = PG_FILL;
         latch_o = 1'b1;
         clear_o = 1'b1;
      end else if (commit_i) begin
         if (state_q == PG_FILL && any_valid_i) begin
            state_d = PG_PROG;
            cnt_d   = '0;
         end else begin
            state_d = PG_IDLE;
            clear_o = 1'b1;
         end
      end else if (load_i && state_q == PG_FILL) begin
         step_o = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PG_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy_o     = (state_q == PG_PROG);
   assign scan_on_o  = busy_o && (cnt_q < CNT_W'(SLOTS));
   assign scan_ofs_o = cnt_q[OFS_W-1:0];
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
   parameter int ADDR_W     = 14,
   parameter int PAGE_BYTES = 64,
   parameter int DATA_W     = 8,
   parameter int TWR_CYCLES = 80,
   parameter bit REG_OUT    = 1'b0,
   localparam int OFS_W  = $clog2(PAGE_BYTES),
   localparam int PAGE_W = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start_i,
   input  logic [ADDR_W-1:0] txn_addr_i,
   input  logic              byte_load_i,
   input  logic [DATA_W-1:0] byte_data_i,
   input  logic              commit_req_i,
   input  logic              abort_req_i,
   output logic              busy_o,
   output logic              arr_we_o,
   output logic [ADDR_W-1:0] arr_addr_o,
   output logic [DATA_W-1:0] arr_data_o
);
   if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (PAGE_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the offset width");
   end
   if (TWR_CYCLES <= PAGE_BYTES + int'(REG_OUT)) begin : g_bad_twr
      $error("TWR_CYCLES must cover the page sweep");
   end

   logic              latch, step, clear, busy;
   logic              scan_on, any_valid, slot_valid;
   logic [OFS_W-1:0]  scan_ofs, cur_ofs;
   logic [PAGE_W-1:0] cur_page;
   logic [DATA_W-1:0] slot_data;

   pgb_ctrl #(
      .SLOTS      (PAGE_BYTES),
      .TWR_CYCLES (TWR_CYCLES)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .abort_i     (abort_req_i),
      .start_i     (txn_start_i),
      .commit_i    (commit_req_i),
      .load_i      (byte_load_i),
      .any_valid_i (any_valid),
      .busy_o      (busy),
      .latch_o     (latch),
      .step_o      (step),
      .clear_o     (clear),
      .scan_on_o   (scan_on),
      .scan_ofs_o  (scan_ofs)
   );

   pgb_cursor #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W)
   ) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch_i (latch),
      .addr_i  (txn_addr_i),
      .step_i  (step),
      .page_o  (cur_page),
      .ofs_o   (cur_ofs)
   );

   pgb_slots #(
      .SLOTS  (PAGE_BYTES),
      .DATA_W (DATA_W)
   ) u_slots (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (clear),
      .wr_i        (step),
      .wr_ofs_i    (cur_ofs),
      .wr_data_i   (byte_data_i),
      .rd_ofs_i    (scan_ofs),
      .rd_data_o   (slot_data),
      .rd_valid_o  (slot_valid),
      .any_valid_o (any_valid)
   );

   logic              we_c;
   logic [ADDR_W-1:0] addr_c;

   assign we_c   = scan_on && slot_valid;
   assign addr_c = {cur_page, scan_ofs};
   assign busy_o = busy;

   if (REG_OUT) begin : g_reg_out
      logic              we_q;
      logic [ADDR_W-1:0] addr_q;
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
         end else begin
            we_q   <= we_c;
            addr_q <= addr_c;
            data_q <= slot_data;
         end
      end
      assign arr_we_o   = we_q;
      assign arr_addr_o = addr_q;
      assign arr_data_o = data_q;
   end else begin : g_comb_out
      assign arr_we_o   = we_c;
      assign arr_addr_o = addr_c;
      assign arr_data_o = slot_data;
   end
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
   parameter int ADDR_W     = 14,
   parameter int OFS_W      = 6,
   parameter int TWR_CYCLES = 80,
   localparam int RUN_W = $clog2(TWR_CYCLES + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              txn_start_i,
   input logic              commit_req_i,
   input logic              abort_req_i,
   input logic              busy_o,
   input logic              arr_we_o,
   input logic [ADDR_W-1:0] arr_addr_o
);
   logic [RUN_W-1:0]  run_q;
   logic              seen_q;
   logic [ADDR_W-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         seen_q <= 1'b0;
         last_q <= '0;
      end else begin
         run_q <= busy_o ? ((run_q == '1) ? run_q : run_q + 1'b1) : '0;
         if (!busy_o) begin
            seen_q <= 1'b0;
         end else if (arr_we_o) begin
            seen_q <= 1'b1;
            last_q <= arr_addr_o;
         end
      end
   end

   AST_BUSY_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (int'(run_q) < TWR_CYCLES));  // R6
   AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (int'(run_q) == TWR_CYCLES));  // R6
   AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(commit_req_i) && !$past(abort_req_i) && !$past(txn_start_i)));  // R10
   AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we_o |-> busy_o);  // R5
   AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we_o && seen_q) |-> (arr_addr_o[OFS_W-1:0] > last_q[OFS_W-1:0]));  // R5
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we_o && seen_q) |-> (arr_addr_o[ADDR_W-1:OFS_W] == last_q[ADDR_W-1:OFS_W]));  // R3
endmodule

bind pgbuf_commit pgbuf_commit_chk #(
   .ADDR_W     (ADDR_W),
   .OFS_W      (OFS_W),
   .TWR_CYCLES (TWR_CYCLES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .txn_start_i  (txn_start_i),
   .commit_req_i (commit_req_i),
   .abort_req_i  (abort_req_i),
   .busy_o       (busy_o),
   .arr_we_o     (arr_we_o),
   .arr_addr_o   (arr_addr_o)
);

// File: tb/sim_pgbuf_commit.sv
`timescale 1ns/1ps
module sim_pgbuf_commit;
   localparam int TWR = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st = 1'b0, ld = 1'b0, cm = 1'b0, ab = 1'b0;
   logic [13:0] ad = '0;
   logic [7:0]  dt = '0;
   logic        busy, we;
   logic [13:0] waddr;
   logic [7:0]  wdata;

   always #5 clk = ~clk;

   pgbuf_commit #(.TWR_CYCLES(TWR)) u0 (
      .clk(clk), .rst_n(rst_n), .txn_start_i(st), .txn_addr_i(ad),
      .byte_load_i(ld), .byte_data_i(dt), .commit_req_i(cm), .abort_req_i(ab),
      .busy_o(busy), .arr_we_o(we), .arr_addr_o(waddr), .arr_data_o(wdata));

   int n_chk = 0, n_fail = 0;
   int wq_addr[$];
   int wq_data[$];
   int bq[$];
   logic [7:0] mem [int];

   // reference model of the staging buffer
   bit [7:0] m_data [64];
   bit       m_val  [64];
   int       m_page, m_ofs, m_busy;
   bit       m_open;

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int rd(int a);
      return mem.exists(a) ? int'(mem[a]) : 32'hFF;
   endfunction

   task automatic mclear();
      for (int i = 0; i < 64; i++) m_val[i] = 1'b0;
   endtask

   task automatic step(bit a_ab, bit a_st, int a_ad, bit a_cm, bit a_ld, int a_dt);
      @(posedge clk); #2;
      ab = a_ab; st = a_st; ad = 14'(a_ad); cm = a_cm; ld = a_ld; dt = 8'(a_dt);
      if (m_busy > 0) begin
         m_busy--;
      end else if (a_ab) begin
         mclear(); m_open = 0;
      end else if (a_st) begin
         mclear(); m_open = 1; m_page = a_ad >> 6; m_ofs = a_ad & 63;
      end else if (a_cm) begin
         bit any = 0;
         for (int i = 0; i < 64; i++) any |= m_val[i];
         if (m_open && any) begin
            for (int i = 0; i < 64; i++)
               if (m_val[i]) begin
                  wq_addr.push_back(m_page * 64 + i);
                  wq_data.push_back(int'(m_data[i]));
               end
            bq.push_back(TWR);
            m_busy = TWR;
         end
         mclear(); m_open = 0;
      end else if (a_ld && m_open) begin
         m_data[m_ofs] = 8'(a_dt); m_val[m_ofs] = 1'b1; m_ofs = (m_ofs + 1) % 64;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
   endtask

   // monitor: compares writes and busy windows against the scoreboard queues
   int run = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (we) begin
            if (wq_addr.size() == 0) begin
               check("R5 unexpected write addr", int'(waddr), -1);
            end else begin
               check("R2 write address", int'(waddr), wq_addr.pop_front());
               check("R4 write data", int'(wdata), wq_data.pop_front());
            end
            mem[int'(waddr)] = wdata;
         end
         if (busy) begin
            run++;
         end else if (run > 0) begin
            if (bq.size() == 0) check("R7 unexpected busy window", run, 0);
            else check("R6 busy length", run, bq.pop_front());
            run = 0;
         end
      end
   end

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      mclear(); m_open = 0; m_busy = 0; m_page = 0; m_ofs = 0;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after reset", int'(busy), 0);
      check("R1 write strobe after reset", int'(we), 0);

      // R2: single byte at 0x1234
      step(0, 1, 14'h1234, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'hA5);
      step(0, 0, 0, 1, 0, 0);
      idle(TWR + 4);
      check("R2 readback 0x1234", rd(14'h1234), 8'hA5);

      // R3: wrap inside page 3 from offset 62
      step(0, 1, 3 * 64 + 62, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'h11);
      step(0, 0, 0, 0, 1, 8'h22);
      step(0, 0, 0, 0, 1, 8'h33);
      step(0, 0, 0, 0, 1, 8'h44);
      step(0, 0, 0, 1, 0, 0);
      idle(TWR + 4);
      check("R3 wrapped byte at page start", rd(3 * 64), 8'h33);
      check("R3 next page untouched", rd(4 * 64), 8'hFF);

      // R4: 70 bytes from offset 10 of page 7
      step(0, 1, 7 * 64 + 10, 0, 0, 0);
      for (int i = 0; i < 70; i++) step(0, 0, 0, 0, 1, i);
      step(0, 0, 0, 1, 0, 0);
      idle(TWR + 4);
      check("R4 overwritten offset 12", rd(7 * 64 + 12), 66);
      check("R4 single-load offset 20", rd(7 * 64 + 20), 10);

      // R7: empty commit and commit after abort
      step(0, 0, 0, 1, 0, 0);
      idle(2);
      check("R7 busy on empty commit", int'(busy), 0);
      step(0, 1, 10 * 64, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'h5A);
      step(1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 0, 0);
      idle(2);
      check("R7 busy after abort", int'(busy), 0);

      // R10: abort wins over load, start wins over commit
      step(0, 1, 11 * 64, 0, 0, 0);
      step(1, 0, 0, 0, 1, 8'h66);
      step(0, 0, 0, 1, 0, 0);
      step(0, 1, 12 * 64, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'h77);
      step(0, 1, 13 * 64, 1, 0, 0);
      step(0, 0, 0, 1, 0, 0);
      idle(3);
      check("R10 busy after priority cases", int'(busy), 0);
      check("R10 no write page 12", rd(12 * 64), 8'hFF);
      check("R10 no write page 11", rd(11 * 64), 8'hFF);

      // R8: second start discards first transaction
      step(0, 1, 20 * 64, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'h12);
      step(0, 1, 21 * 64 + 5, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'h34);
      step(0, 0, 0, 1, 0, 0);
      idle(TWR + 4);
      check("R8 discarded byte", rd(20 * 64), 8'hFF);
      check("R8 kept byte", rd(21 * 64 + 5), 8'h34);

      // R9: requests during busy ignored
      step(0, 1, 30 * 64, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'hC1);
      step(0, 0, 0, 0, 1, 8'hC2);
      step(0, 0, 0, 0, 1, 8'hC3);
      step(0, 0, 0, 1, 0, 0);
      step(0, 1, 31 * 64, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'hEE);
      step(0, 0, 0, 1, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      @(negedge clk);
      check("R9 busy held", int'(busy), 1);
      idle(TWR + 4);
      check("R9 foreign byte absent", rd(31 * 64), 8'hFF);
      check("R9 programmed byte", rd(30 * 64 + 2), 8'hC3);

      // R11: loads after commit without a new start
      step(0, 0, 0, 0, 1, 8'h99);
      step(0, 0, 0, 1, 0, 0);
      idle(3);
      check("R11 busy after closed load", int'(busy), 0);
      check("R11 next offset untouched", rd(30 * 64 + 3), 8'hFF);

      idle(4);
      check("R5 pending writes", wq_addr.size(), 0);
      check("R6 pending busy windows", bq.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule